// File: doc/BRIEF.md
# Sync Presence and Polarity Monitor

This block watches a horizontal and a vertical sync input against a free-running reference clock. Each input first passes a short synchronizer and a de-glitch filter that drops any excursion lasting a single reference clock. The block then measures every complete sync period in reference clocks. Firmware derives the sync frequency by dividing the reference frequency by the reported count. From the same periods it keeps a presence flag per input, with separate set and clear limits so that the flag does not chatter.

A sync's polarity follows from its duty cycle. When the high phase of a period lasts longer than its low phase the sync is reported as negative; otherwise it is reported as positive. On the horizontal input the block also looks for lines whose duty cycle flips relative to the established polarity, which is the signature of a vertical interval carried inside a composite sync. A run of such intervals, one per frame, raises a flag telling software that vertical sync can be separated from the horizontal input.

The limits are parameters given in reference clocks. The defaults suit a 14.31818 MHz reference: a horizontal rate of 10 kHz or more and a vertical rate of 40 Hz or more set presence, and a silence of about 100 ms (10 Hz) clears it.

Top module: `syncmon_top`

## Requirements
- R1: An excursion of either sync input that lasts one clock is ignored and changes no output. An excursion of two or more clocks is measured.
- R2: After two filtered rising edges of a sync, its period output holds the number of clocks between them. The output changes only when a period completes, and the first rising edge after reset changes nothing.
- R3: A period longer than the counter can hold is reported as all-ones (1023 for a 10-bit count).
- R4: A polarity bit is 1 (negative) when the high time of the last period exceeds its low time. It is 0 (positive) when the high time is equal to or shorter than the low time.
- R5: The horizontal presence flag sets when a completed period is at most H_SET_CLKS. It clears once H_CLR_CLKS clocks pass without a rising edge. A period between the two limits keeps the current state.
- R6: The vertical presence flag follows the same rule using V_SET_CLKS and V_CLR_CLKS.
- R7: A horizontal line whose duty-cycle polarity is opposite to the reported horizontal polarity is a wide line. The reported polarity is held through wide lines. It takes the new value only when MAX_WIDE_LINES wide lines arrive in a row.
- R8: A run of 1 to MAX_WIDE_LINES-1 wide lines, followed by a normal line, counts as one vertical interval. The composite flag sets at the CV_FRAMES-th interval when each interval follows the previous one within CV_TIMEOUT_CLKS. It clears when that time passes with no interval, or when horizontal presence drops.
- R9: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Raw horizontal or composite sync |
| vsyncIn | input | 1 | Raw vertical sync |
| hPeriod | output | CNT_W | Last complete horizontal period in clocks |
| vPeriod | output | CNT_W | Last complete vertical period in clocks |
| hPresent | output | 1 | Horizontal sync present |
| vPresent | output | 1 | Vertical sync present |
| hNegative | output | 1 | Horizontal polarity, 1 = negative |
| vNegative | output | 1 | Vertical polarity, 1 = negative |
| compVsyncPresent | output | 1 | Vertical interval found in horizontal input |

## Verification
Period measurement is tried with short, medium and overlong periods. These tell a correct count apart from an off-by-one count and from wrap-around past the counter width. Presence is driven from both the absent and the present state with periods inside the hysteresis band, which shows whether the set and clear limits are kept apart. Duty cycles of mostly high, mostly low and exactly half separate the polarity decision from its tie rule. Composite traffic mixes frames that contain short wide-line runs with long runs and with interval-free stretches. This exposes the difference between counting intervals, adopting a new polarity and timing out.

// File: rtl/syncmon_pkg.sv
package syncmon_pkg;
  localparam int NCH  = 2;
  localparam int CH_H = 0;
  localparam int CH_V = 1;

  typedef struct packed {
    logic [NCH-1:0] capture;   // latch period of the channel this cycle
    logic [NCH-1:0] polWrite;  // also latch polarity of the channel
  } syncmon_strobe_t;
endpackage

// File: rtl/syncmon_datapath.sv
module syncmon_datapath
  import syncmon_pkg::*;
#(
  parameter int CNT_W = 21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCH-1:0]       syncIn,
  input  syncmon_strobe_t      strobe,
  output logic [NCH-1:0]       riseOut,
  output logic [CNT_W-1:0]     runCnt [NCH],
  output logic                 lineNegH,
  output logic [CNT_W-1:0]     periodOut [NCH],
  output logic [NCH-1:0]       negOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NCH-1:0] lineNeg;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic             s1, s2, s3, filt, filtD;
    logic [CNT_W-1:0] cnt, hiCnt, periodNext, periodReg;
    logic             negReg;

    // synchronizer plus de-glitch: a level must be seen on two samples
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
        filt <= 1'b0; filtD <= 1'b0;
      end else begin
        s1 <= syncIn[i];
        s2 <= s1;
        s3 <= s2;
        if (s2 == s3) filt <= s2;
        filtD <= filt;
      end
    end

    assign riseOut[i] = filt & ~filtD;

    // running period and high-time counters, both saturating
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt   <= '0;
        hiCnt <= '0;
      end else if (riseOut[i]) begin
        cnt   <= '0;
        hiCnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (filt && hiCnt != CNT_MAX) hiCnt <= hiCnt + 1'b1;
      end
    end

    assign periodNext = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
    assign lineNeg[i] = {hiCnt, 1'b0} > {1'b0, periodNext};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        periodReg <= '0;
        negReg    <= 1'b0;
      end else if (strobe.capture[i]) begin
        periodReg <= periodNext;
        if (strobe.polWrite[i]) negReg <= lineNeg[i];
      end
    end

    assign runCnt[i]    = cnt;
    assign periodOut[i] = periodReg;
    assign negOut[i]    = negReg;
  end

  assign lineNegH = lineNeg[CH_H];
endmodule

// File: rtl/syncmon_ctrl.sv
module syncmon_ctrl
  import syncmon_pkg::*;
#(
  parameter int CNT_W      = 21,
  parameter int H_SET_CLKS = 1431,
  parameter int H_CLR_CLKS = 1431818,
  parameter int V_SET_CLKS = 357954,
  parameter int V_CLR_CLKS = 1431818,
  parameter int MAX_WIDE_LINES  = 16,
  parameter int CV_FRAMES       = 3,
  parameter int CV_TIMEOUT_CLKS = 1431818
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   riseIn,
  input  logic [CNT_W-1:0] runCnt [NCH],
  input  logic             lineNegH,
  input  logic [CNT_W-1:0] periodIn [NCH],
  input  logic             negH,
  output syncmon_strobe_t  strobe,
  output logic [NCH-1:0]   presentOut,
  output logic             compVsync
);
  localparam int WR_W  = $clog2(MAX_WIDE_LINES + 1);
  localparam int FR_W  = $clog2(CV_FRAMES + 1);
  localparam int TMR_W = $clog2(CV_TIMEOUT_CLKS + 1);
  localparam logic [WR_W-1:0]  WIDE_LAST = WR_W'(MAX_WIDE_LINES - 1);
  localparam logic [FR_W-1:0]  FR_LAST   = FR_W'(CV_FRAMES - 1);
  localparam logic [TMR_W-1:0] TMR_LIM   = TMR_W'(CV_TIMEOUT_CLKS);

  logic [NCH-1:0] armed, capD;
  logic           polWriteH;

  always_comb begin
    strobe.capture  = riseIn & armed;
    strobe.polWrite = {1'b1, polWriteH};
  end

  // presence with hysteresis, one instance per channel
  for (genvar i = 0; i < NCH; i++) begin : g_pres
    localparam logic [CNT_W-1:0] SET_L = CNT_W'((i == CH_H) ? H_SET_CLKS : V_SET_CLKS);
    localparam logic [CNT_W-1:0] CLR_L = CNT_W'((i == CH_H) ? H_CLR_CLKS : V_CLR_CLKS);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armed[i]      <= 1'b0;
        capD[i]       <= 1'b0;
        presentOut[i] <= 1'b0;
      end else begin
        if (riseIn[i]) armed[i] <= 1'b1;
        capD[i] <= strobe.capture[i];
        if (capD[i] && periodIn[i] <= SET_L) presentOut[i] <= 1'b1;
        else if (runCnt[i] >= CLR_L)         presentOut[i] <= 1'b0;
      end
    end
  end

  // composite vertical interval tracking on the horizontal channel
  logic             hPolValid, wideLine, intervalEnd;
  logic [WR_W-1:0]  wideRun;
  logic [FR_W-1:0]  frameCnt;
  logic [TMR_W-1:0] idleTmr;

  assign wideLine    = hPolValid && (lineNegH != negH);
  assign polWriteH   = !hPolValid || !wideLine || (wideRun == WIDE_LAST);
  assign intervalEnd = strobe.capture[CH_H] && !wideLine && (wideRun != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPolValid <= 1'b0;
      wideRun   <= '0;
    end else if (strobe.capture[CH_H]) begin
      hPolValid <= 1'b1;
      if (wideLine && wideRun != WIDE_LAST) wideRun <= wideRun + 1'b1;
      else                                  wideRun <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt  <= '0;
      idleTmr   <= '0;
      compVsync <= 1'b0;
    end else if (!presentOut[CH_H]) begin
      frameCnt  <= '0;
      idleTmr   <= '0;
      compVsync <= 1'b0;
    end else if (intervalEnd) begin
      idleTmr <= '0;
      if (frameCnt != FR_LAST + 1'b1) frameCnt <= frameCnt + 1'b1;
      if (frameCnt >= FR_LAST) compVsync <= 1'b1;
    end else if (idleTmr >= TMR_LIM) begin
      frameCnt  <= '0;
      compVsync <= 1'b0;
    end else begin
      idleTmr <= idleTmr + 1'b1;
    end
  end
endmodule

// File: rtl/syncmon_top.sv
module syncmon_top
  import syncmon_pkg::*;
#(
  parameter int CNT_W      = 21,
  parameter int H_SET_CLKS = 1431,
  parameter int H_CLR_CLKS = 1431818,
  parameter int V_SET_CLKS = 357954,
  parameter int V_CLR_CLKS = 1431818,
  parameter int MAX_WIDE_LINES  = 16,
  parameter int CV_FRAMES       = 3,
  parameter int CV_TIMEOUT_CLKS = 1431818
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  output logic [CNT_W-1:0] hPeriod,
  output logic [CNT_W-1:0] vPeriod,
  output logic             hPresent,
  output logic             vPresent,
  output logic             hNegative,
  output logic             vNegative,
  output logic             compVsyncPresent
);
  syncmon_strobe_t  strobe;
  logic [NCH-1:0]   rise, negVec, presVec;
  logic [CNT_W-1:0] runCnt [NCH];
  logic [CNT_W-1:0] periodVec [NCH];
  logic             lineNegH;

  syncmon_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .syncIn({vsyncIn, hsyncIn}), .strobe(strobe),
    .riseOut(rise), .runCnt(runCnt), .lineNegH(lineNegH),
    .periodOut(periodVec), .negOut(negVec)
  );

  syncmon_ctrl #(
    .CNT_W(CNT_W), .H_SET_CLKS(H_SET_CLKS), .H_CLR_CLKS(H_CLR_CLKS),
    .V_SET_CLKS(V_SET_CLKS), .V_CLR_CLKS(V_CLR_CLKS),
    .MAX_WIDE_LINES(MAX_WIDE_LINES), .CV_FRAMES(CV_FRAMES),
    .CV_TIMEOUT_CLKS(CV_TIMEOUT_CLKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .riseIn(rise), .runCnt(runCnt), .lineNegH(lineNegH),
    .periodIn(periodVec), .negH(negVec[CH_H]), .strobe(strobe),
    .presentOut(presVec), .compVsync(compVsyncPresent)
  );

  assign hPeriod   = periodVec[CH_H];
  assign vPeriod   = periodVec[CH_V];
  assign hPresent  = presVec[CH_H];
  assign vPresent  = presVec[CH_V];
  assign hNegative = negVec[CH_H];
  assign vNegative = negVec[CH_V];
endmodule

// File: rtl/syncmon_checker.sv
module syncmon_checker #(
  parameter int CNT_W      = 21,
  parameter int H_SET_CLKS = 1431,
  parameter int V_SET_CLKS = 357954,
  parameter int V_CLR_CLKS = 1431818
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       capture,
  input logic [CNT_W-1:0] vRunCnt,
  input logic [CNT_W-1:0] hPeriod,
  input logic [CNT_W-1:0] vPeriod,
  input logic             hPresent,
  input logic             vPresent,
  input logic             compVsyncPresent
);
  assert_hperiod_on_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hPeriod) |-> $past(capture[0]));

  assert_vperiod_on_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vPeriod) |-> $past(capture[1]));

  assert_hset_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hPresent) |-> ($past(hPeriod) <= CNT_W'(H_SET_CLKS)));

  assert_vset_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vPresent) |-> ($past(vPeriod) <= CNT_W'(V_SET_CLKS)));

  assert_vclear_timeout_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vPresent) |-> ($past(vRunCnt) >= CNT_W'(V_CLR_CLKS)));

  assert_comp_needs_h_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hPresent |=> !compVsyncPresent);
endmodule

bind syncmon_top syncmon_checker #(
  .CNT_W(CNT_W), .H_SET_CLKS(H_SET_CLKS), .V_SET_CLKS(V_SET_CLKS), .V_CLR_CLKS(V_CLR_CLKS)
) chk_i (
  .clk(clk), .rstN(rstN), .capture(strobe.capture), .vRunCnt(runCnt[1]),
  .hPeriod(hPeriod), .vPeriod(vPeriod), .hPresent(hPresent), .vPresent(vPresent),
  .compVsyncPresent(compVsyncPresent)
);

// File: tb/syncmon_tb_top.sv
module syncmon_tb_top;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncIn = 1'b0;
  logic vsyncIn = 1'b0;
  logic [CNT_W-1:0] hPeriod, vPeriod;
  logic hPresent, vPresent, hNegative, vNegative, compVsyncPresent;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  syncmon_top #(
    .CNT_W(CNT_W), .H_SET_CLKS(40), .H_CLR_CLKS(200),
    .V_SET_CLKS(300), .V_CLR_CLKS(600),
    .MAX_WIDE_LINES(4), .CV_FRAMES(3), .CV_TIMEOUT_CLKS(800)
  ) dut_i (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .hPeriod(hPeriod), .vPeriod(vPeriod), .hPresent(hPresent), .vPresent(vPresent),
    .hNegative(hNegative), .vNegative(vNegative), .compVsyncPresent(compVsyncPresent)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hLine(input int hi, input int lo);
    hsyncIn = 1'b1; idle(hi);
    hsyncIn = 1'b0; idle(lo);
  endtask

  task automatic vLine(input int hi, input int lo);
    vsyncIn = 1'b1; idle(hi);
    vsyncIn = 1'b0; idle(lo);
  endtask

  // 3 wide lines then 27 normal lines: one composite frame
  task automatic hFrame();
    for (int k = 0; k < 3; k++) hLine(16, 4);
    for (int k = 0; k < 27; k++) hLine(4, 16);
  endtask

  task automatic test_reset();
    check("R9 hPeriod", hPeriod, 0);
    check("R9 vPeriod", vPeriod, 0);
    check("R9 hPresent", hPresent, 0);
    check("R9 vPresent", vPresent, 0);
    check("R9 polarity", {hNegative, vNegative}, 0);
    check("R9 compVsync", compVsyncPresent, 0);
  endtask

  task automatic test_h_basic();
    for (int k = 0; k < 4; k++) hLine(5, 15);
    check("R2 hPeriod 20", hPeriod, 20);
    check("R4 hNegative short high", hNegative, 0);
    check("R5 hPresent set", hPresent, 1);
  endtask

  task automatic test_h_hysteresis();
    for (int k = 0; k < 3; k++) hLine(10, 90);
    check("R2 hPeriod 100", hPeriod, 100);
    check("R5 band keeps present", hPresent, 1);
    idle(250);
    check("R5 timeout clears", hPresent, 0);
    for (int k = 0; k < 3; k++) hLine(10, 90);
    check("R5 band keeps absent", hPresent, 0);
    check("R2 hPeriod after gap", hPeriod, 100);
  endtask

  task automatic test_glitch();
    idle(250);
    for (int k = 0; k < 10; k++) hLine(1, 19);
    vLine(1, 30);
    check("R1 hPeriod unchanged", hPeriod, 100);
    check("R1 hPresent unchanged", hPresent, 0);
    check("R1 vPeriod unchanged", vPeriod, 0);
    check("R1 vPresent unchanged", vPresent, 0);
    vLine(2, 40); vLine(2, 40);
    check("R1 two-clock pulses measured", vPeriod, 42);
  endtask

  task automatic test_v();
    for (int k = 0; k < 3; k++) vLine(20, 230);
    check("R2 vPeriod 250", vPeriod, 250);
    check("R6 vPresent set", vPresent, 1);
    for (int k = 0; k < 2; k++) vLine(200, 300);
    check("R6 band keeps present", vPresent, 1);
    check("R2 vPeriod 500", vPeriod, 500);
    for (int k = 0; k < 3; k++) vLine(60, 40);
    check("R4 vNegative long high", vNegative, 1);
    for (int k = 0; k < 2; k++) vLine(50, 50);
    check("R4 equal halves positive", vNegative, 0);
    idle(700);
    check("R6 timeout clears", vPresent, 0);
    for (int k = 0; k < 2; k++) vLine(10, 1090);
    check("R3 saturated period", vPeriod, 1023);
    check("R6 long period absent", vPresent, 0);
  endtask

  task automatic test_composite();
    for (int k = 0; k < 5; k++) hLine(4, 16);
    check("R5 present for composite", hPresent, 1);
    hFrame(); hFrame();
    check("R8 two intervals not enough", compVsyncPresent, 0);
    hFrame();
    check("R8 third interval sets", compVsyncPresent, 1);
    check("R7 polarity held", hNegative, 0);
    check("R2 line period", hPeriod, 20);
    for (int k = 0; k < 45; k++) hLine(4, 16);
    check("R8 timeout clears", compVsyncPresent, 0);
  endtask

  task automatic test_adopt();
    for (int k = 0; k < 3; k++) hLine(16, 4);
    hLine(16, 4);
    check("R7 held below run limit", hNegative, 0);
    hLine(16, 4);
    idle(8);
    check("R7 adopted after run limit", hNegative, 1);
    check("R2 period during adoption", hPeriod, 20);
  endtask

  initial begin
    idle(3);
    test_reset();
    rstN = 1'b1;
    idle(3);
    test_reset();
    test_h_basic();
    test_h_hysteresis();
    test_glitch();
    test_v();
    test_composite();
    test_adopt();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule